// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator

This block produces the colour subcarrier phase for every active pixel of an analogue video encoder. A 12-bit main phase accumulator is advanced by a coarse step on each pixel. Two lower fractional stages trim that step. Each fractional stage has its own modulus, and each one feeds a single-LSB carry into the stage above it. With this chain, a subcarrier frequency that is not an integer fraction of the pixel clock can be held exactly over a long run of pixels.

At field boundaries the whole chain can be re-zeroed, so that the subcarrier phase repeats on a fixed cycle of fields. The period of that cycle is selected from two, four or eight fields, or the re-zeroing can be turned off. The programmed colour-burst peak amplitude is registered and passed on alongside the phase. Sine lookup and modulation are done downstream.

Top module: `subcarrier_phase_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after its release, `phase` and `burst_amp` are zero.
- R2: The main stage (enable `dda_en[0]`) adds `inc_main` plus the carry from the middle stage to `phase` on each pixel cycle (`pix_en` high). The sum wraps modulo 4096.
- R3: The lowest stage (enable `dda_en[2]`) adds `inc_lo` to its 15-bit accumulator on each pixel cycle. When the sum is equal to or greater than `size_lo`, it subtracts `size_lo` once and sends a carry to the middle stage in that same cycle.
- R4: The middle stage (enable `dda_en[1]`) adds `inc_mid` plus the carry from the lowest stage. When the sum reaches `size_mid` or more, it subtracts `size_mid` and sends a carry of one LSB into the main stage in that same cycle.
- R5: A stage whose enable bit is low keeps its accumulator value and sends no carry. A carry arriving at a disabled stage is lost.
- R6: On a cycle with `pix_en` low and no field clear, no accumulator changes.
- R7: A 3-bit field counter counts every `field_start` strobe. `rst_mode` selects the clear period: code 0 clears on every 2nd strobe, code 1 on every 4th and code 2 on every 8th. The clear happens on the strobe that brings the counter to a multiple of the period, and `phase` reads zero on the following cycle.
- R8: With `rst_mode` = 3, the strobes are still counted, but the accumulators are never cleared.
- R9: A field clear takes priority over a pixel advance in the same cycle.
- R10: `burst_amp` equals the value that `burst_lvl` held one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Advance the chain on this cycle |
| field_start | input | 1 | One-cycle strobe at each field start |
| dda_en | input | 3 | Stage enables: bit 0 main, bit 1 middle, bit 2 lowest |
| inc_main | input | 12 | Main stage step |
| inc_mid | input | 15 | Middle stage step |
| size_mid | input | 15 | Middle stage modulus |
| inc_lo | input | 15 | Lowest stage step |
| size_lo | input | 15 | Lowest stage modulus |
| rst_mode | input | 2 | Field clear period select |
| burst_lvl | input | 8 | Programmed burst amplitude |
| phase | output | 12 | Subcarrier phase |
| burst_amp | output | 8 | Registered burst amplitude |

## Verification
Only the main accumulator can be seen at the ports, so the hardest case to reach is a carry that ripples through both fractional stages in a single pixel cycle. The same applies to a carry that is lost at a disabled middle stage. The stimulus uses small moduli with steps close to them, which makes carries frequent. It then switches single enable bits while the chain is running, and the effect of each lost or passed carry shows up as a one-LSB difference in `phase`. The field counter's phase relative to the selected period is also only indirectly visible. To test it, `rst_mode` is changed between strobe trains without a reset, so a clear can land partway through a new period.

// File: rtl/scphase_pkg.sv
package scphase_pkg;
  typedef enum logic [1:0] {
    FLD_EVERY2 = 2'd0,
    FLD_EVERY4 = 2'd1,
    FLD_EVERY8 = 2'd2,
    FLD_NEVER  = 2'd3
  } fld_period_e;

  // Low-bit mask whose all-zero state marks the end of a period
  function automatic logic [2:0] period_mask(input fld_period_e m);
    case (m)
      FLD_EVERY2: return 3'b001;
      FLD_EVERY4: return 3'b011;
      default:    return 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/frac_dda_stage.sv
module frac_dda_stage #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] inc,
  input  logic [W-1:0] size,
  input  logic         cin,
  output logic         cout
);
  localparam int SW = W + 1;

  typedef struct packed {
    logic         carry;
    logic [W-1:0] nxt;
  } step_t;

  // One modular step: add, compare, subtract the modulus once
  function automatic step_t mod_step(input logic [W-1:0] a, input logic [W-1:0] d,
                                     input logic c, input logic [W-1:0] m);
    logic [SW-1:0] s;
    step_t r;
    s = {1'b0, a} + {1'b0, d} + SW'(c);
    if (s >= {1'b0, m}) begin
      r.carry = 1'b1;
      s = s - {1'b0, m};
    end else begin
      r.carry = 1'b0;
    end
    r.nxt = s[W-1:0];
    return r;
  endfunction

  logic [W-1:0] acc;
  step_t        st;

  always_comb st = mod_step(acc, inc, cin, size);
  assign cout = adv & st.carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (adv) acc <= st.nxt;
  end
endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] inc,
  input  logic         cin,
  output logic [W-1:0] phase
);
  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] a, input logic [W-1:0] d,
                                            input logic c);
    return a + d + W'(c);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase <= '0;
    else if (clr) phase <= '0;
    else if (adv) phase <= wrap_add(phase, inc, cin);
  end
endmodule

// File: rtl/field_reset_ctrl.sv
module field_reset_ctrl
  import scphase_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       field_start,
  input  logic [1:0] mode,
  output logic       clear
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  fld_period_e      pm;

  assign pm      = fld_period_e'(mode);
  assign cnt_nxt = cnt + CNT_W'(1);
  assign clear   = field_start && (pm != FLD_NEVER) &&
                   ((cnt_nxt & CNT_W'(period_mask(pm))) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (field_start) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/subcarrier_phase_gen.sv
module subcarrier_phase_gen #(
  parameter int PHASE_W = 12,
  parameter int FRAC_W  = 15,
  parameter int LVL_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_en,
  input  logic               field_start,
  input  logic [2:0]         dda_en,
  input  logic [PHASE_W-1:0] inc_main,
  input  logic [FRAC_W-1:0]  inc_mid,
  input  logic [FRAC_W-1:0]  size_mid,
  input  logic [FRAC_W-1:0]  inc_lo,
  input  logic [FRAC_W-1:0]  size_lo,
  input  logic [1:0]         rst_mode,
  input  logic [LVL_W-1:0]   burst_lvl,
  output logic [PHASE_W-1:0] phase,
  output logic [LVL_W-1:0]   burst_amp
);
  localparam int CNT_W = 3;

  logic field_clear;
  logic carry3;
  logic carry2;

  field_reset_ctrl #(.CNT_W(CNT_W)) u_fld (
    .clk(clk), .rst_n(rst_n), .field_start(field_start),
    .mode(rst_mode), .clear(field_clear)
  );

  frac_dda_stage #(.W(FRAC_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .clr(field_clear),
    .adv(pix_en & dda_en[2]), .inc(inc_lo), .size(size_lo),
    .cin(1'b0), .cout(carry3)
  );

  frac_dda_stage #(.W(FRAC_W)) u_mid (
    .clk(clk), .rst_n(rst_n), .clr(field_clear),
    .adv(pix_en & dda_en[1]), .inc(inc_mid), .size(size_mid),
    .cin(carry3), .cout(carry2)
  );

  phase_accum #(.W(PHASE_W)) u_main (
    .clk(clk), .rst_n(rst_n), .clr(field_clear),
    .adv(pix_en & dda_en[0]), .inc(inc_main), .cin(carry2),
    .phase(phase)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_amp <= '0;
    else        burst_amp <= burst_lvl;
  end
endmodule

// File: rtl/subcarrier_phase_checker.sv
module subcarrier_phase_checker #(
  parameter int PHASE_W = 12,
  parameter int LVL_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pix_en,
  input logic               field_start,
  input logic [2:0]         dda_en,
  input logic [1:0]         rst_mode,
  input logic [LVL_W-1:0]   burst_lvl,
  input logic [PHASE_W-1:0] phase,
  input logic [LVL_W-1:0]   burst_amp,
  input logic               carry3,
  input logic               carry2,
  input logic               field_clear
);
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    field_clear |=> (phase == '0));

  p_clear_needs_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    field_clear |-> field_start);

  p_never_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_mode == 2'd3) |-> !field_clear);

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (field_clear && pix_en && dda_en[0]) |=> (phase == '0));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en && !field_clear) |=> $stable(phase));

  p_lo_off_nocarry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dda_en[2] |-> !carry3);

  p_mid_off_nocarry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dda_en[1] |-> !carry2);

  p_main_off_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dda_en[0] && !field_clear) |=> $stable(phase));

  p_carry_needs_pixel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (carry3 || carry2) |-> pix_en);

  p_burst_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (burst_amp == $past(burst_lvl)));
endmodule

bind subcarrier_phase_gen subcarrier_phase_checker #(.PHASE_W(PHASE_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .field_start(field_start),
  .dda_en(dda_en), .rst_mode(rst_mode), .burst_lvl(burst_lvl),
  .phase(phase), .burst_amp(burst_amp), .carry3(carry3), .carry2(carry2),
  .field_clear(field_clear)
);

// File: tb/tb_subcarrier_phase_gen.sv
`timescale 1ns/1ps
module tb_subcarrier_phase_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_en;
  logic        field_start;
  logic [2:0]  dda_en;
  logic [11:0] inc_main;
  logic [14:0] inc_mid, size_mid, inc_lo, size_lo;
  logic [1:0]  rst_mode;
  logic [7:0]  burst_lvl;
  logic [11:0] phase;
  logic [7:0]  burst_amp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int m_main, m_mid, m_lo, m_cnt, m_burst;

  always #2.5 clk = ~clk;

  subcarrier_phase_gen dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .field_start(field_start),
    .dda_en(dda_en), .inc_main(inc_main), .inc_mid(inc_mid), .size_mid(size_mid),
    .inc_lo(inc_lo), .size_lo(size_lo), .rst_mode(rst_mode), .burst_lvl(burst_lvl),
    .phase(phase), .burst_amp(burst_amp)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // behavioural model of one clock edge
  task automatic model_tick();
    bit clr = 0;
    int per, c_lo = 0, c_mid = 0, t;
    if (field_start) begin
      m_cnt = (m_cnt + 1) % 8;
      per = (rst_mode == 0) ? 2 : (rst_mode == 1) ? 4 : (rst_mode == 2) ? 8 : 0;
      if (per != 0 && (m_cnt % per) == 0) clr = 1;
    end
    if (clr) begin
      m_main = 0; m_mid = 0; m_lo = 0;
    end else if (pix_en) begin
      if (dda_en[2]) begin
        t = m_lo + int'(inc_lo);
        if (t >= int'(size_lo)) begin t -= int'(size_lo); c_lo = 1; end
        m_lo = t % 32768;
      end
      if (dda_en[1]) begin
        t = m_mid + int'(inc_mid) + c_lo;
        if (t >= int'(size_mid)) begin t -= int'(size_mid); c_mid = 1; end
        m_mid = t % 32768;
      end
      if (dda_en[0]) m_main = (m_main + int'(inc_main) + c_mid) % 4096;
    end
    m_burst = int'(burst_lvl);
  endtask

  task automatic cycle(input string req, input bit pe, input bit fs);
    pix_en = pe;
    field_start = fs;
    model_tick();
    @(negedge clk);
    check(req, "phase", int'(phase), m_main);
    check(req, "burst_amp", int'(burst_amp), m_burst);
  endtask

  task automatic run(input string req, input int n, input bit pe);
    for (int i = 0; i < n; i++) cycle(req, pe, 1'b0);
  endtask

  task automatic fields(input string req, input int nfld, input int gap);
    for (int f = 0; f < nfld; f++) begin
      cycle(req, 1'b1, 1'b1);
      for (int g = 0; g < gap; g++) cycle(req, 1'b1, 1'b0);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pix_en = 0; field_start = 0; dda_en = 3'b000;
    inc_main = 0; inc_mid = 0; size_mid = 1; inc_lo = 0; size_lo = 1;
    rst_mode = 2'd3; burst_lvl = 0;
    m_main = 0; m_mid = 0; m_lo = 0; m_cnt = 0; m_burst = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "phase", int'(phase), 0);
    check("R1", "burst_amp", int'(burst_amp), 0);
    rst_n = 1;
    cycle("R1", 1'b0, 1'b0);

    // R2: main stage alone, including wrap
    dda_en = 3'b001; inc_main = 12'h123;
    run("R2", 20, 1'b1);
    inc_main = 12'hFFF;
    run("R2", 10, 1'b1);

    // R3: lowest stage carries through a zero-step middle stage
    dda_en = 3'b111; inc_main = 12'd0; inc_lo = 15'd3; size_lo = 15'd7;
    inc_mid = 15'd0; size_mid = 15'd5;
    run("R3", 60, 1'b1);

    // R4: middle stage carries into the main stage
    inc_main = 12'd1; inc_lo = 15'd0; inc_mid = 15'd10000; size_mid = 15'd30000;
    run("R4", 40, 1'b1);
    // both stages close to their moduli: double ripple
    inc_lo = 15'd6; size_lo = 15'd7; inc_mid = 15'd4; size_mid = 15'd5;
    run("R4", 40, 1'b1);

    // R5: enables switched while running
    dda_en = 3'b101; run("R5", 20, 1'b1);
    dda_en = 3'b011; run("R5", 20, 1'b1);
    dda_en = 3'b110; run("R5", 20, 1'b1);
    dda_en = 3'b000; run("R5", 10, 1'b1);
    dda_en = 3'b111; run("R5", 20, 1'b1);

    // R6: no pixel cycles
    inc_main = 12'd77;
    run("R6", 20, 1'b0);

    // R7: each clear period, mode changed without reset
    rst_mode = 2'd0; fields("R7", 6, 4);
    rst_mode = 2'd1; fields("R7", 9, 3);
    rst_mode = 2'd2; fields("R7", 17, 2);
    rst_mode = 2'd1; fields("R7", 5, 5);

    // R8: never clear
    rst_mode = 2'd3; fields("R8", 12, 3);

    // R9: strobes on back-to-back pixel cycles
    rst_mode = 2'd0; fields("R9", 10, 0);

    // R10: burst level varies every cycle
    for (int i = 0; i < 30; i++) begin
      burst_lvl = 8'((i * 37 + 11) & 8'hFF);
      cycle("R10", 1'b1, 1'b0);
    end

    // mixed stimulus
    for (int i = 0; i < 300; i++) begin
      if (i % 25 == 0) begin
        inc_main = 12'($urandom); inc_lo = 15'($urandom_range(0, 300));
        size_lo = 15'($urandom_range(1, 400)); inc_mid = 15'($urandom_range(0, 3000));
        size_mid = 15'($urandom_range(1, 4000)); dda_en = 3'($urandom);
        rst_mode = 2'($urandom);
      end
      burst_lvl = 8'($urandom);
      cycle("R3", 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 9) == 0));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule